// File: doc/BRIEF.md
# Burst-Mode Pipelined Page DRAM Model

This block is a synthesizable, clocked behavioural model of the device side of a page-mode DRAM that supports four-word bursts. A controller drives a multiplexed address bus and three active-low strobes: row strobe, column strobe and write enable. The model samples all of them on its own clock and acts on their falling and rising edges. A falling row strobe opens a row. The first falling column strobe of a burst takes a column address from the bus. An internal beat counter then supplies the other three columns of the aligned group of four. The controller therefore needs to present only one column address per burst.

Read data passes through a prefetch stage and an output register. The first column strobe after a row opens puts nothing on the outputs. Each later falling column strobe presents the word fetched on the strobe before it, which gives a 4-1-1-1 burst. Output data stays valid while the column strobe is high. It changes only on the next falling column strobe. A rising row strobe ends the burst, clears the pipeline and turns the output enable off. A falling column strobe with write enable low stores the input word at the current burst column instead of reading.

Top module: `bedo_dram`

## Requirements
- R1: While reset is asserted and after its release, `dout_en` is low until read data has moved through the pipeline.
- R2: A row strobe falling edge latches the row from `addr[ROW_W-1:0]`. A column strobe falling edge seen while no row is open is ignored.
- R3: On the first column strobe falling edge after a row opens, `dout_en` and `dout` are unchanged.
- R4: Beat k of a burst (k = 0..3) uses column `{base[COL_W-1:2], (base[1:0]+k) mod 4}`. Here `base` is `addr[COL_W-1:0]`, taken only at beat 0. After beat 3 the next falling edge is beat 0 of a new burst.
- R5: Each read beat fetches its word. The next column strobe falling edge loads that word into `dout` and sets `dout_en` high. This includes the beat 0 edge of the following burst.
- R6: A rising column strobe, or a clock with no column strobe falling edge, leaves `dout` unchanged.
- R7: A column strobe falling edge with `we_n` low writes `din` to the current burst column. It puts no word into the pipeline, so the next falling edge presents nothing new.
- R8: A rising row strobe drives `dout_en` low, returns the burst to beat 0 and empties the pipeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| we_n | input | 1 | Active-low write enable, sampled at column strobe fall |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | DW | Write data |
| dout | output | DW | Registered read data |
| dout_en | output | 1 | Output enable; low means the bus is released |

## Verification
On every clock, the assertions check the following. Output data moves only after a falling column strobe. The first beat after a row opens stays silent. A write beat leaves the pipeline empty. A high row strobe forces beat zero and turns the output enable off.

Only the bench's sweep can show that each word is correct. The sweep covers every row, every column group and every starting offset. It checks that column wrap-around follows the requirement and that the deferred fourth word appears on the next burst's first edge.

// File: rtl/bedo_dram.sv
module bedo_dram #(
  parameter int DW     = 8,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     din,
  output logic [DW-1:0]     dout,
  output logic              dout_en
);
  localparam int IDX_W = ROW_W + COL_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0]    mem [DEPTH];
  logic             ras_q, cas_q, row_open, stage_vld;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_base;
  logic [1:0]       pos;
  logic [DW-1:0]    stage;

  wire ras_fall = ras_q & ~ras_n;
  wire ras_rise = ~ras_q & ras_n;
  wire cas_fall = cas_q & ~cas_n & row_open & ~ras_n;
  wire [1:0]       lane    = col_base[1:0] + pos;
  wire [COL_W-1:0] col_now = (pos == 2'd0) ? addr[COL_W-1:0]
                                           : {col_base[COL_W-1:2], lane};
  wire [IDX_W-1:0] idx     = {row_q, col_now};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q     <= 1'b1;
      cas_q     <= 1'b1;
      row_open  <= 1'b0;
      row_q     <= '0;
      col_base  <= '0;
      pos       <= 2'd0;
      stage     <= '0;
      stage_vld <= 1'b0;
      dout      <= '0;
      dout_en   <= 1'b0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      if (ras_fall) begin
        row_open <= 1'b1;
        row_q    <= addr[ROW_W-1:0];
        pos      <= 2'd0;
      end else if (ras_rise) begin
        row_open  <= 1'b0;
        pos       <= 2'd0;
        stage_vld <= 1'b0;
        dout_en   <= 1'b0;
      end else if (cas_fall) begin
        if (pos == 2'd0) col_base <= addr[COL_W-1:0];
        pos <= pos + 2'd1;
        if (stage_vld) begin
          dout    <= stage;
          dout_en <= 1'b1;
        end
        stage_vld <= we_n;
        if (we_n) stage <= mem[idx];
      end
    end
  end

  always_ff @(posedge clk)
    if (cas_fall && !we_n) mem[idx] <= din;

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cas_n) |-> $stable(dout)); // R6
  AST_FIRST_BEAT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cas_fall && !stage_vld) |-> $stable(dout) && $stable(dout_en)); // R3
  AST_WRITE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cas_fall && !we_n) |-> !stage_vld); // R7
  AST_CLOSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ras_n) |-> !dout_en && pos == 2'd0); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !dout_en); // R1
endmodule

// File: tb/bedo_dram_tb_top.sv
module bedo_dram_tb_top;
  localparam int PERIOD = 10;
  localparam int DW = 8, ROW_W = 2, COL_W = 4, ADDR_W = 4;
  localparam int NROW = 1 << ROW_W, NGRP = (1 << COL_W) / 4;

  logic clk = 1'b0, rst_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DW-1:0] din = '0, dout;
  logic dout_en;
  int vectors = 0, fails = 0;
  logic [DW-1:0] model [NROW << COL_W];

  bedo_dram #(.DW(DW), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int r, input int c);
    return DW'((r * 53 + c * 29 + 7) & 8'hFF);
  endfunction

  task automatic open_row(input int r);
    @(negedge clk); addr = ADDR_W'(r); ras_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic close_row();
    @(negedge clk); ras_n = 1'b1;
    @(negedge clk);
    chk(dout_en == 1'b0, "R8 enable after row close", dout_en, 0);
  endtask

  task automatic beat(input int col, input bit wr, input logic [DW-1:0] d);
    @(negedge clk); addr = ADDR_W'(col); we_n = ~wr; din = d; cas_n = 1'b0;
    @(negedge clk); cas_n = 1'b1; we_n = 1'b1;
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dout_en == 1'b0, "R1 enable in reset", dout_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dout_en == 1'b0, "R1 enable after reset", dout_en, 0);

    beat(5, 1'b0, '0); beat(6, 1'b0, '0);
    chk(dout_en == 1'b0, "R2 strobe with row closed ignored", dout_en, 0);

    for (int r = 0; r < NROW; r++) begin
      open_row(r);
      for (int g = 0; g < NGRP; g++) begin
        int s;
        s = g % 4;
        for (int k = 0; k < 4; k++) begin
          int c;
          c = g * 4 + ((s + k) % 4);
          model[(r << COL_W) + c] = pat(r, c);
          beat(k == 0 ? g * 4 + s : 0, 1'b1, pat(r, c));
          chk(dout_en == 1'b0, "R7 write beat drives nothing", dout_en, 0);
        end
      end
      beat(0, 1'b0, '0);
      chk(dout_en == 1'b0, "R7 first read after writes silent", dout_en, 0);
      close_row();
    end

    for (int r = 0; r < NROW; r++)
      for (int g = 0; g < NGRP; g++)
        for (int s = 0; s < 4; s++) begin
          logic [DW-1:0] held;
          open_row(r);
          for (int k = 0; k < 5; k++) begin
            beat(g * 4 + s, 1'b0, '0);
            if (k == 0) begin
              chk(dout_en == 1'b0, "R3 first beat silent", dout_en, 0);
            end else begin
              int c;
              logic [DW-1:0] e;
              c = g * 4 + ((s + k - 1) % 4);
              e = model[(r << COL_W) + c];
              chk(dout_en == 1'b1, "R5 enable on later beat", dout_en, 1);
              chk(dout == e, k == 4 ? "R5 fourth word on next edge" : "R4 burst column word", dout, e);
              held = dout;
              @(negedge clk);
              chk(dout == held, "R6 data held with strobe high", dout, held);
            end
          end
          close_row();
        end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule